// File: doc/BRIEF.md
# DRAM Strobe Sequence Decoder

This block sits on the device side of an asynchronous DRAM interface and stands in for the memory when a DRAM controller is under test. A fast system clock samples the active-low row strobe, column strobe, write enable and output enable along with the multiplexed address. From the order in which those strobes fall and rise, the block works out what kind of cycle the controller has started. It then carries that cycle out on a small behavioural array that can be mapped to block RAM.

Each cycle the block recognises produces a one-clock event carrying a kind code. The latched row and column addresses and the data-bus drive enable are also visible at the ports. A refresh started with the column strobe already low takes its row from an internal refresh counter and ignores the address bus. The block checks only the order of strobe edges. It does not check analog timing.

Every output is registered. A strobe pattern sampled at one rising clock edge shows up at the outputs just after that edge. Edges are detected by comparing the current sample with the sample taken one clock earlier.

Top module: `dram_strobe_decoder`

## Requirements
- R1: If the column strobe is low when the row strobe falls, the block emits a counter-refresh event (kind 6). `row_q` takes the refresh counter value and the address bus is ignored.
- R2: The refresh counter starts at 0 after reset. It advances by one after each counter-refresh event and wraps from 1023 to 0.
- R3: A row strobe fall with the column strobe high, followed by a row strobe rise with no column strobe fall in between, emits a row-refresh event (kind 5) when the row strobe rises. `row_q` holds the row address captured at the fall.
- R4: With write enable high, a read starts at whichever of the column strobe fall and the output enable fall comes later. It emits kind 1, raises `dq_oe`, and places the stored word for {row, column} on `dout`.
- R5: If write enable is already low when the column strobe falls, the block stores `din` at the new column and emits kind 2, and `dq_oe` stays low.
- R6: If write enable falls while the column strobe is low, the block stores `din` at the latched column. The event is kind 4 when a read already started in that column access, and kind 3 otherwise. `dq_oe` is low after either.
- R7: `dq_oe` is low one clock after any sample with both row and column strobes high. It is also low one clock after any rise of output enable.
- R8: Read data stays driven after the column strobe rises. At the next column strobe fall within the same row, the new column's data replaces it.
- R9: Each event lasts exactly one clock and appears one clock after the sample that triggers it. `evt_valid` is low on every other clock.
- R10: If the row strobe rises and falls again while the column strobe stays low after a read, the result is a counter refresh. Read data stays driven while the row strobe is high and is turned off when the refresh starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| row_strobe_n | input | 1 | Active-low row address strobe |
| col_strobe_n | input | 1 | Active-low column address strobe |
| wr_en_n | input | 1 | Active-low write enable |
| out_en_n | input | 1 | Active-low output enable |
| mux_addr | input | AW | Multiplexed row/column address |
| din | input | DW | Write data from the bus |
| evt_valid | output | 1 | One-clock cycle event strobe |
| evt_kind | output | 3 | Event kind: 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 row refresh, 6 counter refresh |
| row_q | output | AW | Latched row (or refresh counter value) |
| col_q | output | AW | Latched column |
| dout | output | DW | Read data |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The embedded properties check the local relations on every clock. They confirm that the bus is released after both strobes are seen high or after output enable rises, and that each event kind matches the strobe levels sampled one clock before it. They also confirm that the refresh counter only moves on a refresh. Only the scripted scenarios can show the rest. These cover the data that round-trips through the array, the data held across a column strobe rise, the late-start read chosen by output enable, the hidden refresh, and the wrap of the refresh counter after more than a thousand refreshes.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  typedef enum logic [2:0] {
    EV_NONE     = 3'd0,
    EV_READ     = 3'd1,
    EV_WR_EARLY = 3'd2,
    EV_WR_LATE  = 3'd3,
    EV_RMW      = 3'd4,
    EV_ROW_REF  = 3'd5,
    EV_CTR_REF  = 3'd6
  } ev_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPEN,
    ST_CTR
  } row_st_t;

  typedef enum logic [1:0] {
    PH_NONE,
    PH_WAIT,
    PH_READ
  } col_ph_t;
endpackage

// File: rtl/dsd_refresh_ctr.sv
module dsd_refresh_ctr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  p_ctr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt));
  p_ctr_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (inc && cnt == '1) |=> cnt == '0);
endmodule

// File: rtl/dsd_array.sv
module dsd_array #(
  parameter int IW = 8,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << IW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
  import dsd_pkg::*;
#(
  parameter int AW           = 10,
  parameter int DW           = 4,
  parameter int MEM_ROW_BITS = 4,
  parameter int MEM_COL_BITS = 4,
  parameter int REF_BITS     = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          row_strobe_n,
  input  logic          col_strobe_n,
  input  logic          wr_en_n,
  input  logic          out_en_n,
  input  logic [AW-1:0] mux_addr,
  input  logic [DW-1:0] din,
  output logic          evt_valid,
  output logic [2:0]    evt_kind,
  output logic [AW-1:0] row_q,
  output logic [AW-1:0] col_q,
  output logic [DW-1:0] dout,
  output logic          dq_oe
);
  localparam int IW = MEM_ROW_BITS + MEM_COL_BITS;

  // previous strobe samples: [0] row, [1] col, [2] write, [3] output enable
  logic [3:0] prev_q;
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 4'hF;
    else     prev_q <= {out_en_n, wr_en_n, col_strobe_n, row_strobe_n};
  end

  logic ras_fall, ras_rise, cas_fall, we_fall, oe_fall, oe_rise;
  assign ras_fall = prev_q[0] & ~row_strobe_n;
  assign ras_rise = ~prev_q[0] & row_strobe_n;
  assign cas_fall = prev_q[1] & ~col_strobe_n;
  assign we_fall  = prev_q[2] & ~wr_en_n;
  assign oe_fall  = prev_q[3] & ~out_en_n;
  assign oe_rise  = ~prev_q[3] & out_en_n;

  row_st_t st, st_d;
  col_ph_t ph, ph_d;
  ev_kind_t kind_q, ev_d;
  logic any_col, any_col_d;
  logic [AW-1:0] row_d, col_d;
  logic drive_d, mem_we, mem_re, ctr_inc;
  logic [REF_BITS-1:0] ref_cnt;
  logic [MEM_COL_BITS-1:0] acc_col;
  logic [IW-1:0] acc_idx;

  assign acc_col = cas_fall ? mux_addr[MEM_COL_BITS-1:0] : col_q[MEM_COL_BITS-1:0];
  assign acc_idx = {row_q[MEM_ROW_BITS-1:0], acc_col};

  dsd_refresh_ctr #(.W(REF_BITS)) u_ref (
    .clk(clk), .rst(rst), .inc(ctr_inc), .cnt(ref_cnt)
  );

  dsd_array #(.IW(IW), .DW(DW)) u_arr (
    .clk(clk), .we(mem_we), .waddr(acc_idx), .wdata(din),
    .re(mem_re), .raddr(acc_idx), .rdata(dout)
  );

  always_comb begin
    st_d = st; ph_d = ph; any_col_d = any_col;
    row_d = row_q; col_d = col_q; drive_d = dq_oe;
    ev_d = EV_NONE; mem_we = 1'b0; mem_re = 1'b0; ctr_inc = 1'b0;
    if (oe_rise) drive_d = 1'b0;
    case (st)
      ST_IDLE, ST_CTR: begin
        if (st == ST_CTR) drive_d = 1'b0;
        if (ras_fall && !col_strobe_n) begin
          ev_d = EV_CTR_REF; row_d = AW'(ref_cnt); ctr_inc = 1'b1;
          drive_d = 1'b0; st_d = ST_CTR;
        end else if (ras_fall) begin
          row_d = mux_addr; any_col_d = 1'b0; ph_d = PH_NONE; st_d = ST_OPEN;
        end else if (st == ST_CTR && row_strobe_n && col_strobe_n) begin
          st_d = ST_IDLE;
        end
      end
      ST_OPEN: begin
        if (ras_rise) begin
          if (!any_col) ev_d = EV_ROW_REF;
          st_d = ST_IDLE; ph_d = PH_NONE;
        end else if (cas_fall) begin
          col_d = mux_addr; any_col_d = 1'b1; drive_d = 1'b0;
          if (!wr_en_n) begin
            mem_we = 1'b1; ev_d = EV_WR_EARLY; ph_d = PH_NONE;
          end else if (!out_en_n) begin
            mem_re = 1'b1; drive_d = 1'b1; ev_d = EV_READ; ph_d = PH_READ;
          end else begin
            ph_d = PH_WAIT;
          end
        end else if (!col_strobe_n) begin
          case (ph)
            PH_WAIT: begin
              if (we_fall) begin
                mem_we = 1'b1; ev_d = EV_WR_LATE; ph_d = PH_NONE;
              end else if (oe_fall && wr_en_n) begin
                mem_re = 1'b1; drive_d = 1'b1; ev_d = EV_READ; ph_d = PH_READ;
              end
            end
            PH_READ: begin
              if (we_fall) begin
                mem_we = 1'b1; ev_d = EV_RMW; drive_d = 1'b0; ph_d = PH_NONE;
              end
            end
            default: ;
          endcase
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (row_strobe_n && col_strobe_n) drive_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; ph <= PH_NONE; any_col <= 1'b0;
      row_q <= '0; col_q <= '0; dq_oe <= 1'b0;
      evt_valid <= 1'b0; kind_q <= EV_NONE;
    end else begin
      st <= st_d; ph <= ph_d; any_col <= any_col_d;
      row_q <= row_d; col_q <= col_d; dq_oe <= drive_d;
      evt_valid <= (ev_d != EV_NONE); kind_q <= ev_d;
    end
  end
  assign evt_kind = kind_q;

  p_hiz_both_high_r7: assert property (@(posedge clk) disable iff (rst)
    (row_strobe_n && col_strobe_n) |=> !dq_oe);
  p_oe_release_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(out_en_n) |=> !dq_oe);
  p_ctr_lead_r1: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind == EV_CTR_REF) |-> $past(!col_strobe_n && !row_strobe_n));
  p_early_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind == EV_WR_EARLY) |-> (!dq_oe && $past(!wr_en_n)));
  p_read_drive_r4: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind == EV_READ) |->
      (dq_oe && $past(wr_en_n && !out_en_n && !col_strobe_n)));
  p_row_ref_r3: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind == EV_ROW_REF) |-> $past(row_strobe_n && col_strobe_n));
endmodule

// File: tb/test_dram_strobe_decoder.sv
module test_dram_strobe_decoder;
  localparam int AW = 10;
  localparam int DW = 4;
  localparam logic [2:0] K_READ = 3'd1, K_EWR = 3'd2, K_LWR = 3'd3,
                         K_RMW = 3'd4, K_ROW = 3'd5, K_CTR = 3'd6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic row_strobe_n = 1'b1, col_strobe_n = 1'b1, wr_en_n = 1'b1, out_en_n = 1'b1;
  logic [AW-1:0] mux_addr = '0;
  logic [DW-1:0] din = '0;
  logic evt_valid, dq_oe;
  logic [2:0] evt_kind;
  logic [AW-1:0] row_q, col_q;
  logic [DW-1:0] dout;

  always #2 clk = ~clk;

  dram_strobe_decoder i_dram_strobe_decoder (
    .clk(clk), .rst(rst), .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n),
    .wr_en_n(wr_en_n), .out_en_n(out_en_n), .mux_addr(mux_addr), .din(din),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .row_q(row_q), .col_q(col_q),
    .dout(dout), .dq_oe(dq_oe)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  string cur_req = "R9";
  logic [DW-1:0] bmem [int];
  int bref = 0;

  logic exp_oe = 1'b0, exp_ev = 1'b0;
  logic [DW-1:0] exp_dq = '0;
  logic [2:0] exp_kind = '0;
  logic [AW-1:0] exp_row = '0, exp_col = '0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // reference comparison every clock: inputs change 1 ns after the edge
  task automatic tick();
    @(posedge clk);
    #1;
    chk(cur_req, "dq_oe", {31'd0, dq_oe}, {31'd0, exp_oe});
    if (exp_oe) chk(cur_req, "dout", {28'd0, dout}, {28'd0, exp_dq});
    chk({cur_req, "/R9"}, "evt_valid", {31'd0, evt_valid}, {31'd0, exp_ev});
    if (exp_ev && evt_valid) begin
      chk(cur_req, "evt_kind", {29'd0, evt_kind}, {29'd0, exp_kind});
      chk(cur_req, "row_q", {22'd0, row_q}, {22'd0, exp_row});
      if (exp_kind <= K_RMW) chk(cur_req, "col_q", {22'd0, col_q}, {22'd0, exp_col});
    end
    exp_ev = 1'b0;
  endtask

  function automatic int key(logic [AW-1:0] r, logic [AW-1:0] c);
    return int'({r[3:0], c[3:0]});
  endfunction

  task automatic expect_ev(logic [2:0] k, logic [AW-1:0] r, logic [AW-1:0] c);
    exp_ev = 1'b1; exp_kind = k; exp_row = r; exp_col = c;
  endtask

  task automatic open_row(logic [AW-1:0] r);
    row_strobe_n = 1'b0; mux_addr = r; tick();
  endtask

  task automatic close_all();
    row_strobe_n = 1'b1; col_strobe_n = 1'b1; wr_en_n = 1'b1; out_en_n = 1'b1;
    exp_oe = 1'b0; tick(); tick();
  endtask

  task automatic early_write(logic [AW-1:0] r, logic [AW-1:0] c, logic [DW-1:0] d);
    cur_req = "R5";
    open_row(r);
    wr_en_n = 1'b0; din = d; tick();
    mux_addr = c; col_strobe_n = 1'b0; expect_ev(K_EWR, r, c); exp_oe = 1'b0;
    bmem[key(r, c)] = d; tick();
    close_all();
  endtask

  // leaves the column strobe and output enable low with data driven
  task automatic read_col(logic [AW-1:0] r, logic [AW-1:0] c, bit oe_late);
    cur_req = "R4";
    open_row(r);
    mux_addr = c; col_strobe_n = 1'b0;
    if (oe_late) begin
      exp_oe = 1'b0; tick();
      out_en_n = 1'b0;
    end else begin
      out_en_n = 1'b0;
    end
    expect_ev(K_READ, r, c); exp_oe = 1'b1; exp_dq = bmem[key(r, c)];
    tick();
  endtask

  task automatic ctr_refresh();
    cur_req = "R1";
    col_strobe_n = 1'b0; tick();
    mux_addr = 10'h155; row_strobe_n = 1'b0;
    expect_ev(K_CTR, AW'(bref % 1024), '0); bref++; exp_oe = 1'b0; tick();
    row_strobe_n = 1'b1; tick();
    col_strobe_n = 1'b1; tick();
  endtask

  initial begin
    #(4 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R7", "reset dq_oe", {31'd0, dq_oe}, 32'd0);
    chk("R9", "reset evt_valid", {31'd0, evt_valid}, 32'd0);
    rst = 1'b0;
    tick();

    early_write(10'd3, 10'd5, 4'hA);
    early_write(10'd3, 10'd6, 4'h5);
    early_write(10'd7, 10'd1, 4'hC);

    // page read, data held over column strobe rise, released when both high
    read_col(10'd3, 10'd5, 1'b0);
    cur_req = "R8";
    col_strobe_n = 1'b1; tick();
    mux_addr = 10'd6; col_strobe_n = 1'b0;
    expect_ev(K_READ, 10'd3, 10'd6); exp_dq = 4'h5; tick();
    col_strobe_n = 1'b1; tick();
    cur_req = "R7";
    row_strobe_n = 1'b1; exp_oe = 1'b0; tick();
    close_all();

    // read started by output enable, then released by output enable rise
    read_col(10'd7, 10'd1, 1'b1);
    cur_req = "R7";
    out_en_n = 1'b1; exp_oe = 1'b0; tick();
    close_all();

    // late write with no read
    cur_req = "R6";
    open_row(10'd7);
    mux_addr = 10'd2; col_strobe_n = 1'b0; tick();
    wr_en_n = 1'b0; din = 4'h9; expect_ev(K_LWR, 10'd7, 10'd2);
    bmem[key(10'd7, 10'd2)] = 4'h9; tick();
    close_all();

    // read-modify-write
    read_col(10'd3, 10'd5, 1'b0);
    cur_req = "R6";
    out_en_n = 1'b1; exp_oe = 1'b0; tick();
    wr_en_n = 1'b0; din = 4'h3; expect_ev(K_RMW, 10'd3, 10'd5);
    bmem[key(10'd3, 10'd5)] = 4'h3; tick();
    close_all();

    read_col(10'd7, 10'd2, 1'b0); close_all();
    read_col(10'd3, 10'd5, 1'b1); close_all();

    // row-only refresh
    cur_req = "R3";
    open_row(10'h2AB);
    row_strobe_n = 1'b1; expect_ev(K_ROW, 10'h2AB, '0); tick();
    tick();

    ctr_refresh();

    // hidden refresh after a read
    read_col(10'd7, 10'd1, 1'b0);
    cur_req = "R10";
    row_strobe_n = 1'b1; tick();
    row_strobe_n = 1'b0; expect_ev(K_CTR, AW'(bref % 1024), '0); bref++;
    exp_oe = 1'b0; tick();
    close_all();

    // counter wrap
    for (int i = 0; i < 1030; i++) begin
      ctr_refresh();
      if (bref == 1025) begin
        cur_req = "R2";
        chk("R2", "wrapped row", {22'd0, row_q}, 32'd0);
      end
    end
    read_col(10'd7, 10'd2, 1'b0); close_all();

    report();
  end
endmodule